// File: doc/BRIEF.md
# UART Interrupt Generator with Per-Source Masking

This block produces the interrupt lines of a serial port. It watches four sources: the fill level of the receive FIFO, the fill level of the transmit FIFO, three active-low modem status lines, and a receive-timeout event pulse. Each source drives its own active-high interrupt through an enable bit. A fifth output is the OR of the enabled interrupts. The FIFOs, the shifter, the baud logic and the timeout counter are outside this block. Their occupancy counts and event pulses arrive as inputs.

The receive and transmit interrupts are plain level conditions on the FIFO counts. Their thresholds change with the FIFO mode input: either a 16-entry FIFO or a single holding location. Because they are levels, they can drive DMA requests directly. The modem-status and timeout interrupts are latched events. Software reads the raw and masked status vectors, and it clears the modem-status latch with a strobe.

Status vectors use one bit position per source: bit 0 is modem status, bit 1 is receive, bit 2 is receive timeout and bit 3 is transmit.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While and after reset, the raw status, the masked status, the enable mask and all five interrupt outputs are 0.
- R2: A cycle with `mask_wr_en` high loads `mask_wr_data` into the enable mask, with bit 0 for modem status, bit 1 for receive, bit 2 for timeout and bit 3 for transmit. A 1 enables the source. The new mask applies to the outputs from the clock edge that loads it.
- R3: `raw_status` shows every source's state whatever the mask holds. `masked_status` equals raw AND mask. Each individual interrupt output equals its masked bit.
- R4: `irq_any` is high exactly when at least one masked status bit is high.
- R5: With `fifo_en` high, the raw receive bit is high one edge after `rx_count` is 8 or more, and low one edge after `rx_count` drops below 8.
- R6: With `fifo_en` high, the raw transmit bit is high one edge after `tx_count` is 8 or less (room for 8 or more), and low one edge after `tx_count` exceeds 8.
- R7: With `fifo_en` low (one-entry mode), the raw receive bit follows `rx_count` != 0 and the raw transmit bit follows `tx_count` == 0, each one edge later.
- R8: The modem lines pass through a two-flop synchronizer whose flops reset to 1 (idle). A level change on any line, in either direction, sets the raw modem-status bit at the third clock edge after the change.
- R9: The modem-status bit stays set until a `ms_clr` strobe, which clears it at that edge. A change detected at the same edge wins over the clear.
- R10: A `rt_pulse` sets the timeout bit at the next edge, and the bit holds. The bit clears at the edge where `rx_read` is high or `rx_count` is 0. The clear wins over a pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1: 16-entry FIFO mode, 0: one-entry mode |
| rx_count | input | 5 | Receive FIFO occupancy |
| tx_count | input | 5 | Transmit FIFO occupancy |
| rx_read | input | 1 | Pulse: receive FIFO was read |
| rt_pulse | input | 1 | Pulse: receive timeout expired |
| modem_n | input | 3 | Active-low modem status lines (asynchronous) |
| mask_wr_en | input | 1 | Write strobe for the enable mask |
| mask_wr_data | input | 4 | Enable mask value |
| ms_clr | input | 1 | Clear strobe for the modem-status latch |
| raw_status | output | 4 | Unmasked source status |
| masked_status | output | 4 | Status ANDed with the mask |
| irq_ms | output | 1 | Modem-status interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_rt | output | 1 | Receive-timeout interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_any | output | 1 | OR of the enabled interrupts |

## Verification
Results fall due at different delays:
- Level, timeout and mask results follow their inputs after exactly one clock edge.
- A modem line change shows up at the third edge, after two synchronizer stages and one edge-compare stage.

The bench drives every input just after a falling edge. It advances a reference model at the next rising edge, from the same inputs the design registers there, and compares all outputs at the following falling edge. Each comparison therefore lands exactly in the cycle where the design's registered result becomes visible. Directed sequences place threshold counts of 7, 8 and 9, a clear strobe coincident with a detected modem change, and a timeout pulse coincident with a read.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int unsigned SRC_NUM = 4;

    // Bit order of every status vector: tx rt rx ms (ms is bit 0)
    typedef struct packed {
        logic tx;
        logic rt;
        logic rx;
        logic ms;
    } irq_vec_t;
endpackage

// File: rtl/irq_modem_watch.sv
module irq_modem_watch #(
    parameter int unsigned LINES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines_n,
    input  logic             clr,
    output logic             flag
);
    typedef struct packed {
        logic [LINES-1:0] stage1;
        logic [LINES-1:0] stage2;
        logic [LINES-1:0] prev;
        logic             flag;
    } mw_state_t;

    mw_state_t st_d, st_q;
    logic      change;

    always_comb begin
        st_d        = st_q;
        change      = (st_q.stage2 != st_q.prev);
        st_d.stage1 = lines_n;
        st_d.stage2 = st_q.stage1;
        st_d.prev   = st_q.stage2;
        // a detected change takes priority over the clear strobe
        st_d.flag   = change | (st_q.flag & ~clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.stage1 <= '1;
            st_q.stage2 <= '1;
            st_q.prev   <= '1;
            st_q.flag   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

    assert_ms_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !clr) |=> st_q.flag);
    assert_ms_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (st_q.stage2 == st_q.prev)) |=> !st_q.flag);
    assert_ms_detect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stage2 != st_q.prev) |=> st_q.flag);
endmodule

// File: rtl/irq_flow_level.sv
module irq_flow_level #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    output logic             rx_lvl,
    output logic             tx_lvl
);
    localparam logic [CNT_W-1:0] THRESH = CNT_W'(DEPTH / 2);

    typedef struct packed {
        logic rx;
        logic tx;
    } fl_state_t;

    fl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fifo_en) begin
            st_d.rx = (rx_count >= THRESH);
            st_d.tx = (tx_count <= THRESH);
        end else begin
            st_d.rx = (rx_count != '0);
            st_d.tx = (tx_count == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_lvl = st_q.rx;
    assign tx_lvl = st_q.tx;

    assert_rx_fifo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && rx_count < THRESH) |=> !st_q.rx);
    assert_tx_fifo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && tx_count > THRESH) |=> !st_q.tx);
    assert_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && rx_count == '0) |=> !st_q.rx);
endmodule

// File: rtl/irq_timeout_latch.sv
module irq_timeout_latch #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse,
    input  logic             rd,
    input  logic [CNT_W-1:0] rx_count,
    output logic             flag
);
    typedef struct packed {
        logic flag;
    } tl_state_t;

    tl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd || rx_count == '0) st_d.flag = 1'b0;
        else if (pulse)           st_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    assert_rt_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd || rx_count == '0) |=> !st_q.flag);
    assert_rt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !rd && rx_count != '0) |=> st_q.flag);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned LINES  = 3,
    parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_en,
    input  logic [CNT_W-1:0]   rx_count,
    input  logic [CNT_W-1:0]   tx_count,
    input  logic               rx_read,
    input  logic               rt_pulse,
    input  logic [LINES-1:0]   modem_n,
    input  logic               mask_wr_en,
    input  logic [SRC_NUM-1:0] mask_wr_data,
    input  logic               ms_clr,
    output logic [SRC_NUM-1:0] raw_status,
    output logic [SRC_NUM-1:0] masked_status,
    output logic               irq_ms,
    output logic               irq_rx,
    output logic               irq_rt,
    output logic               irq_tx,
    output logic               irq_any
);
    typedef struct packed {
        irq_vec_t mask;
    } top_state_t;

    top_state_t st_d, st_q;
    irq_vec_t   raw, act;
    logic       ms_flag, rt_flag, rx_lvl, tx_lvl;

    irq_modem_watch #(.LINES(LINES)) i_modem (
        .clk(clk), .rst_n(rst_n), .lines_n(modem_n), .clr(ms_clr), .flag(ms_flag)
    );

    irq_flow_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_flow (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .rx_count(rx_count), .tx_count(tx_count),
        .rx_lvl(rx_lvl), .tx_lvl(tx_lvl)
    );

    irq_timeout_latch #(.CNT_W(CNT_W)) i_tmo (
        .clk(clk), .rst_n(rst_n), .pulse(rt_pulse), .rd(rx_read),
        .rx_count(rx_count), .flag(rt_flag)
    );

    always_comb begin
        st_d = st_q;
        if (mask_wr_en) st_d.mask = irq_vec_t'(mask_wr_data);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        raw.ms = ms_flag;
        raw.rx = rx_lvl;
        raw.rt = rt_flag;
        raw.tx = tx_lvl;
        act    = raw & st_q.mask;
    end

    assign raw_status    = raw;
    assign masked_status = act;
    assign irq_ms        = act.ms;
    assign irq_rx        = act.rx;
    assign irq_rt        = act.rt;
    assign irq_tx        = act.tx;
    assign irq_any       = |act;

    assert_mask_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask == '0) |-> !irq_any);
    assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_en |=> (st_q.mask == $past(mask_wr_data)));
    assert_outputs_sub_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((masked_status & ~raw_status) == '0));
endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       fifo_en;
    logic [4:0] rx_count, tx_count;
    logic       rx_read, rt_pulse;
    logic [2:0] modem_n;
    logic       mask_wr_en;
    logic [3:0] mask_wr_data;
    logic       ms_clr;
    logic [3:0] raw_status, masked_status;
    logic       irq_ms, irq_rx, irq_rt, irq_tx, irq_any;

    int checks = 0;
    int bad    = 0;

    // reference model state
    logic [2:0] m1, m2, m3;
    logic       e_ms, e_rx, e_rt, e_tx;
    logic [3:0] e_mask;

    always #10 clk = ~clk;

    uart_irq_ctrl i_uart_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_count(rx_count),
        .tx_count(tx_count), .rx_read(rx_read), .rt_pulse(rt_pulse),
        .modem_n(modem_n), .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .ms_clr(ms_clr), .raw_status(raw_status), .masked_status(masked_status),
        .irq_ms(irq_ms), .irq_rx(irq_rx), .irq_rt(irq_rt), .irq_tx(irq_tx),
        .irq_any(irq_any)
    );

    function automatic logic f_rx(input logic fe, input logic [4:0] c);
        return fe ? (c >= 5'd8) : (c != 5'd0);
    endfunction

    function automatic logic f_tx(input logic fe, input logic [4:0] c);
        return fe ? (c <= 5'd8) : (c == 5'd0);
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m1 = 3'b111; m2 = 3'b111; m3 = 3'b111;
        e_ms = 0; e_rx = 0; e_rt = 0; e_tx = 0; e_mask = 4'h0;
    endtask

    task automatic compare_all();
        logic [3:0] raw, msk;
        raw = {e_tx, e_rt, e_rx, e_ms};
        msk = raw & e_mask;
        chk("R8/R9 ms", {3'b0, raw_status[0]}, {3'b0, raw[0]});
        chk(fifo_en ? "R5 rx" : "R7 rx", {3'b0, raw_status[1]}, {3'b0, raw[1]});
        chk("R10 rt", {3'b0, raw_status[2]}, {3'b0, raw[2]});
        chk(fifo_en ? "R6 tx" : "R7 tx", {3'b0, raw_status[3]}, {3'b0, raw[3]});
        chk("R2 masked", masked_status, msk);
        chk("R3 lines", {irq_tx, irq_rt, irq_rx, irq_ms}, msk);
        chk("R4 any", {3'b0, irq_any}, {3'b0, |msk});
    endtask

    // one clock: model advances from the inputs held across the rising edge
    task automatic step();
        logic chg;
        @(posedge clk);
        chg  = (m2 != m3);
        e_ms = chg | (e_ms & ~ms_clr);
        m3 = m2; m2 = m1; m1 = modem_n;
        e_rx = f_rx(fifo_en, rx_count);
        e_tx = f_tx(fifo_en, tx_count);
        if (rx_read || rx_count == 5'd0) e_rt = 1'b0;
        else if (rt_pulse)               e_rt = 1'b1;
        if (mask_wr_en) e_mask = mask_wr_data;
        @(negedge clk);
        compare_all();
        mask_wr_en = 0; ms_clr = 0; rx_read = 0; rt_pulse = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; fifo_en = 1; rx_count = 0; tx_count = 0; rx_read = 0;
        rt_pulse = 0; modem_n = 3'b111; mask_wr_en = 0; mask_wr_data = 0; ms_clr = 0;
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 raw", raw_status, 4'h0);
        chk("R1 masked", masked_status, 4'h0);
        chk("R1 lines", {irq_tx, irq_rt, irq_rx, irq_ms}, 4'h0);
        chk("R1 any", {3'b0, irq_any}, 4'h0);
        rst_n = 1; rx_count = 5'd4; tx_count = 5'd16;
        step();
        // R1: mask empty after reset -> no outputs even with raw sources
        chk("R1 mask", masked_status, 4'h0);

        // R2: enable all sources
        mask_wr_en = 1; mask_wr_data = 4'hF; step();

        // R5 threshold directed (FIFO mode)
        rx_count = 5'd7; step();
        rx_count = 5'd8; step();
        rx_count = 5'd7; step();
        // R6 threshold directed
        tx_count = 5'd8; step();
        tx_count = 5'd9; step();
        tx_count = 5'd8; step();

        // R8: modem change detected after three edges; R9 clear
        modem_n = 3'b101; step(); step(); step();
        chk("R8 detect", {3'b0, raw_status[0]}, 4'h1);
        step(); ms_clr = 1; step();
        chk("R9 clear", {3'b0, raw_status[0]}, 4'h0);
        // R9: clear coincident with detection -> set wins
        modem_n = 3'b111; step(); step(); ms_clr = 1; step();
        chk("R9 set wins", {3'b0, raw_status[0]}, 4'h1);
        ms_clr = 1; step();

        // R10: pulse sets, holds, read clears; pulse+read -> clear wins
        rx_count = 5'd3; rt_pulse = 1; step();
        chk("R10 set", {3'b0, raw_status[2]}, 4'h1);
        step(); chk("R10 hold", {3'b0, raw_status[2]}, 4'h1);
        rt_pulse = 1; rx_read = 1; step();
        chk("R10 clear wins", {3'b0, raw_status[2]}, 4'h0);

        // R3: masked-off source still raw
        mask_wr_en = 1; mask_wr_data = 4'b0101; rx_count = 5'd12; step();
        chk("R3 raw rx", {3'b0, raw_status[1]}, 4'h1);
        chk("R3 irq_rx off", {3'b0, irq_rx}, 4'h0);

        // R7: one-entry mode
        fifo_en = 0; rx_count = 5'd1; tx_count = 5'd0; step();
        rx_count = 5'd0; tx_count = 5'd1; step();

        // random mix
        for (int i = 0; i < 3000; i++) begin
            if (i % 250 == 0) fifo_en = ~fifo_en;
            rx_count = fifo_en ? 5'($urandom_range(0, 16)) : 5'($urandom_range(0, 1));
            tx_count = fifo_en ? 5'($urandom_range(0, 16)) : 5'($urandom_range(0, 1));
            rx_read  = ($urandom_range(0, 5) == 0);
            rt_pulse = ($urandom_range(0, 4) == 0);
            ms_clr   = ($urandom_range(0, 6) == 0);
            if ($urandom_range(0, 7) == 0) modem_n[$urandom_range(0, 2)] ^= 1'b1;
            if ($urandom_range(0, 9) == 0) begin
                mask_wr_en = 1; mask_wr_data = 4'($urandom);
            end
            step();
        end

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule